// File: doc/BRIEF.md
# Character-Cell Pixel Serializer

This block produces the monochrome pixel stream of a text display that is 50 characters wide and 32 text rows tall, with each text row 8 scanlines high, giving a picture of 400 by 256 pixels. For every character cell it reads a one-byte character code from screen memory and uses that code to pick one byte from a 2 KB glyph table. The byte chosen is row (line mod 8) of glyph (code). It then shifts the eight pixels of that byte onto the video output, spending two clock cycles on each pixel.

A timing generator supplies a window strobe that marks the active part of a scanline and the number of the picture line being drawn. While the strobe is low the block prefetches column 0 of the current line, so the first pixel is ready on the first cycle of the window. During each character it fetches the next character into a staging register. That staged byte moves into the shifter on the same edge that retires the last pixel of the current character, so no blank pixel appears between characters. Both memories are read through synchronous ports with one cycle of latency.

Top module: `char_pixel_serializer`

## Requirements
- R1: During window cycle p (p = 0 on the first cycle the strobe is high), the video output equals bit (7 - (p mod 16)/2) of the glyph byte for column p/16. Bit 7 is shown first, and a 1 bit drives the output high.
- R2: Each pixel is held on the output for exactly 2 consecutive clock cycles. A new pixel may begin only on an even window cycle.
- R3: The screen read address is (line/8)*50 + column. While the strobe is low it presents column 0 of the current line. During character c of the window it presents column c+1.
- R4: The glyph read address is code*8 + (line mod 8). The code occupies bits 10..3 and the glyph row occupies bits 2..0. The address is presented one cycle after the matching screen address.
- R5: The first pixel of character c+1 appears on the cycle immediately after the last pixel of character c, with no blank cycle between them.
- R6: The video output is low on every cycle in which the window strobe is low.
- R7: A window of 800 cycles shows 50 characters, and character 0 is correct from the first window cycle. This holds provided the line number is stable and the strobe is low for at least 4 cycles before the window opens.
- R8: After synchronous reset, with the strobe low, the video output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (two cycles per pixel) |
| rst | input | 1 | Synchronous active-high reset |
| win_i | input | 1 | Active-window strobe from the timing generator |
| line_i | input | 8 | Picture line number, 0 to 255 |
| scr_addr_o | output | 11 | Screen memory read address |
| scr_data_i | input | 8 | Screen memory read data, one cycle after the address |
| glyph_addr_o | output | 11 | Glyph memory read address |
| glyph_data_i | input | 8 | Glyph memory read data, one cycle after the address |
| video_o | output | 1 | Monochrome pixel output, high is white |

## Verification
The video output is combinational from the shift register and the strobe, so the pixel for window cycle p is due in cycle p itself. The bench samples it on the falling edge of that same cycle. The screen address responds in the same cycle as the strobe and the character position. The glyph address follows one cycle later, because it is formed from the registered screen data. The bench therefore checks the screen address mid-character and checks both addresses on the last idle cycle before a window, after at least 4 idle cycles. Each line is compared cycle by cycle against a reference that indexes the bench's own memory arrays. It includes a line with only the minimum 4 idle cycles, and a screen row made entirely of solid glyphs, where any gap between characters would show up as a low pixel.

// File: rtl/cps_pkg.sv
package cps_pkg;
    localparam int COLS      = 50;
    localparam int ROWS      = 32;
    localparam int GLYPH_H   = 8;
    localparam int PIX_W     = 8;
    localparam int PIX_CYC   = 2;
    localparam int CELL_CYC  = PIX_W * PIX_CYC;
    localparam int PH_W      = $clog2(CELL_CYC);
    localparam int COL_W     = $clog2(COLS);
    localparam int GR_W      = $clog2(GLYPH_H);
    localparam int LINE_W    = $clog2(ROWS * GLYPH_H);
    localparam int IDX_W     = 8;
    localparam int SA_W      = $clog2(COLS * ROWS + 1);
    localparam int GA_W      = IDX_W + GR_W;
    localparam int CAP_PH    = 2;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [PH_W-1:0]  ph;
    } cell_pos_t;

    function automatic logic last_cycle(input cell_pos_t p);
        return p.ph == PH_W'(CELL_CYC - 1);
    endfunction

    function automatic logic pixel_end(input cell_pos_t p);
        return (int'(p.ph) % PIX_CYC) == PIX_CYC - 1;
    endfunction
endpackage

// File: rtl/cps_cell_timer.sv
module cps_cell_timer
    import cps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      win_i,
    output cell_pos_t pos_o
);
    always_ff @(posedge clk) begin
        if (rst || !win_i) begin
            pos_o <= '0;
        end else if (last_cycle(pos_o)) begin
            pos_o.ph  <= '0;
            pos_o.col <= (pos_o.col == COL_W'(COLS - 1)) ? '0 : pos_o.col + 1'b1;
        end else begin
            pos_o.ph <= pos_o.ph + 1'b1;
        end
    end

    a_r7_col_range: assert property (@(posedge clk) disable iff (rst)
        int'(pos_o.col) < COLS);

    a_r7_window_start: assert property (@(posedge clk) disable iff (rst)
        $rose(win_i) |-> (pos_o == '0));
endmodule

// File: rtl/cps_fetch_unit.sv
module cps_fetch_unit
    import cps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              win_i,
    input  logic [LINE_W-1:0] line_i,
    input  cell_pos_t         pos_i,
    input  logic [IDX_W-1:0]  scr_data_i,
    input  logic [PIX_W-1:0]  glyph_data_i,
    output logic [SA_W-1:0]   scr_addr_o,
    output logic [GA_W-1:0]   glyph_addr_o,
    output logic [PIX_W-1:0]  stage_o
);
    logic [COL_W:0]  fetch_col;
    logic [SA_W-1:0] row_base;

    always_comb begin
        fetch_col    = win_i ? ({1'b0, pos_i.col} + (COL_W+1)'(1)) : '0;
        row_base     = SA_W'(line_i[LINE_W-1:GR_W]) * SA_W'(COLS);
        scr_addr_o   = row_base + SA_W'(fetch_col);
        glyph_addr_o = {scr_data_i, line_i[GR_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_o <= '0;
        end else if (!win_i || pos_i.ph == PH_W'(CAP_PH)) begin
            stage_o <= glyph_data_i;
        end
    end

    a_r5_stage_hold: assert property (@(posedge clk) disable iff (rst)
        (win_i && pos_i.ph != PH_W'(CAP_PH)) |=> $stable(stage_o));
endmodule

// File: rtl/cps_pixel_shifter.sv
module cps_pixel_shifter
    import cps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             win_i,
    input  cell_pos_t        pos_i,
    input  logic [PIX_W-1:0] stage_i,
    output logic             video_o
);
    logic [PIX_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (!win_i || last_cycle(pos_i)) begin
            shreg <= stage_i;
        end else if (pixel_end(pos_i)) begin
            shreg <= {shreg[PIX_W-2:0], 1'b0};
        end
    end

    assign video_o = win_i & shreg[PIX_W-1];

    a_r2_pixel_pair: assert property (@(posedge clk) disable iff (rst)
        (win_i && !pixel_end(pos_i)) |=> (!win_i || video_o == $past(video_o)));
endmodule

// File: rtl/char_pixel_serializer.sv
module char_pixel_serializer
    import cps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        win_i,
    input  logic [7:0]  line_i,
    output logic [10:0] scr_addr_o,
    input  logic [7:0]  scr_data_i,
    output logic [10:0] glyph_addr_o,
    input  logic [7:0]  glyph_data_i,
    output logic        video_o
);
    cell_pos_t        pos;
    logic [PIX_W-1:0] stage;

    cps_cell_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .win_i (win_i),
        .pos_o (pos)
    );

    cps_fetch_unit u_fetch (
        .clk          (clk),
        .rst          (rst),
        .win_i        (win_i),
        .line_i       (line_i),
        .pos_i        (pos),
        .scr_data_i   (scr_data_i),
        .glyph_data_i (glyph_data_i),
        .scr_addr_o   (scr_addr_o),
        .glyph_addr_o (glyph_addr_o),
        .stage_o      (stage)
    );

    cps_pixel_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .win_i   (win_i),
        .pos_i   (pos),
        .stage_i (stage),
        .video_o (video_o)
    );

    a_r5_seamless: assert property (@(posedge clk) disable iff (rst)
        (win_i && last_cycle(pos)) |=> (!win_i || video_o == $past(stage[PIX_W-1])));

    a_r6_dark_outside: assert property (@(posedge clk) disable iff (rst)
        $fell(win_i) |-> !video_o);
endmodule

// File: tb/char_pixel_serializer_tb.sv
module char_pixel_serializer_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win = 1'b0;
    logic [7:0]  line = '0;
    logic [10:0] scr_addr, glyph_addr;
    logic [7:0]  scr_q = '0, glyph_q = '0;
    logic        video;

    logic [7:0] scr_mem   [0:2047];
    logic [7:0] glyph_mem [0:2047];

    int total = 0;
    int bad   = 0;
    int pcur  = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    char_pixel_serializer u_dut (
        .clk          (clk),
        .rst          (rst),
        .win_i        (win),
        .line_i       (line),
        .scr_addr_o   (scr_addr),
        .scr_data_i   (scr_q),
        .glyph_addr_o (glyph_addr),
        .glyph_data_i (glyph_q),
        .video_o      (video)
    );

    always @(posedge clk) begin
        scr_q   <= scr_mem[scr_addr];
        glyph_q <= glyph_mem[glyph_addr];
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s line=%0d p=%0d act=%0d exp=%0d", tag, line, pcur, act, exp);
        end
    endtask

    function automatic int exp_pix(input int l, input int p);
        int code, g;
        code = int'(scr_mem[(l/8)*50 + p/16]);
        g    = int'(glyph_mem[code*8 + l%8]);
        return (g >> (7 - (p%16)/2)) & 1;
    endfunction

    task automatic tick();
        @(negedge clk);
        if (!win) begin
            chk("R6 dark outside window", int'(video), 0);
        end else begin
            if (pcur < 2)
                chk("R7 first character", int'(video), exp_pix(int'(line), pcur));
            else if (pcur % 16 < 2)
                chk("R5 gapless boundary", int'(video), exp_pix(int'(line), pcur));
            else if (pcur % 2 == 1)
                chk("R2 pixel held", int'(video), exp_pix(int'(line), pcur));
            else
                chk("R1 pixel value", int'(video), exp_pix(int'(line), pcur));
            if (pcur % 16 == 5)
                chk("R3 next-column address", int'(scr_addr),
                    (int'(line)/8)*50 + pcur/16 + 1);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run_line(input int l, input int idle);
        line = 8'(l);
        win  = 1'b0;
        for (int i = 0; i < idle; i++) begin
            if (i == idle - 1) begin
                @(negedge clk);
                chk("R3 idle address", int'(scr_addr), (l/8)*50);
                chk("R4 glyph address", int'(glyph_addr),
                    int'(scr_mem[(l/8)*50])*8 + l%8);
                @(posedge clk);
                #1;
            end else begin
                tick();
            end
        end
        for (int p = 0; p < 800; p++) begin
            win  = 1'b1;
            pcur = p;
            tick();
        end
        win = 1'b0;
        tick();
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            scr_mem[i]   = (i < 50) ? 8'hFF : 8'((i*13 + i/7 + 1) % 256);
            glyph_mem[i] = (i/8 == 255) ? 8'hFF : 8'((i*29 + 5) ^ (i/8));
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset state", int'(video), 0);
        @(posedge clk);
        #1;
        run_line(0, 6);
        run_line(7, 6);
        run_line(8, 4);
        run_line(100, 5);
        run_line(171, 4);
        run_line(255, 8);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule